// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block generates the column address for every beat of a synchronous DRAM read or write burst. A controller gives it a start column together with a burst length code, a burst ordering choice (sequential or interleaved) and a write-single option, plus strobes for read, write, burst stop and precharge. Once a read or write is accepted, the block walks through the column sequence on its own, one column per clock. It raises a busy flag for as long as the burst lasts.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the start column. Full-page bursts step through all 256 columns of the row, wrapping around, and keep going until a stop, a precharge or a new command ends them. A new read or write is accepted on any cycle, including the middle of a burst, and restarts the sequence from its own start column. Row handling, bank selection and data movement belong to the surrounding controller.

Top module: `sdram_col_seq`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is applied and whenever no burst is running, `busy` is 0 and `col_out` is 0.
- R2: An accepted command at a clock edge makes `busy` 1 and `col_out` equal to the sampled `start_col` from that edge on. A fixed burst of length BL (`bl_code` 000=1, 001=2, 010=4, 011=8) holds `busy` for exactly BL cycles, and `busy` is 0 in the cycle after.
- R3: With `bt_ilv`=0 and a fixed length BL, beat n shows the start column with its low log2(BL) bits replaced by (start + n) mod BL. The upper bits do not change during the burst.
- R4: With `bt_ilv`=1 and a fixed length BL, beat n shows the start column with its low log2(BL) bits XORed with n. The upper bits do not change during the burst.
- R5: `bl_code` 111 with `bt_ilv`=0 selects full page: beat n is (start + n) mod 256, and the burst never ends by itself.
- R6: `cmd_stop` or `cmd_pre` without an accepted command ends a running burst: `busy` and `col_out` are 0 from the next edge on.
- R7: An accepted read or write during a burst restarts it from the new start column and with the new settings. An accepted command wins over `cmd_stop` and `cmd_pre` in the same cycle, and `cmd_rd` wins over `cmd_wr` in the same cycle.
- R8: A read or write whose settings are invalid is ignored. The invalid settings are `bl_code` 111 with `bt_ilv`=1, and `bl_code` 100, 101 or 110. An ignored command leaves a running burst continuing unchanged and leaves an idle block idle.
- R9: With `wr_single`=1, a write (`cmd_wr` with `cmd_rd` low) is always accepted as a single beat, whatever the length code and ordering. Reads keep the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_rd | input | 1 | Read command strobe |
| cmd_wr | input | 1 | Write command strobe |
| cmd_stop | input | 1 | Burst stop strobe |
| cmd_pre | input | 1 | Precharge strobe, ends the burst |
| start_col | input | 8 | Start column sampled with a command |
| bl_code | input | 3 | Burst length code |
| bt_ilv | input | 1 | 0 sequential order, 1 interleaved order |
| wr_single | input | 1 | Writes are single-beat when 1 |
| col_out | output | 8 | Column for the current beat, 0 when idle |
| busy | output | 1 | High while a burst is running |

## Verification
Every result shows up one clock edge after its cause. A command sampled at an edge gives beat 0 in the cycle that follows, and each later edge moves to the next beat. A stop, precharge or final beat clears `busy` at the next edge. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge, so each beat is compared halfway through the cycle where it is due. The expected column is worked out in the bench from the start column's offset inside its block, or from plain addition for full page. Every start column is swept for each fixed length and both orderings.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
  localparam int COL_W = 8;
  localparam int LG_W  = 2;

  typedef struct packed {
    logic            full;
    logic            ilv;
    logic [LG_W-1:0] lg;
  } burst_cfg_t;

  // Accepted length/order combinations
  function automatic logic cfg_ok(input logic [2:0] code, input logic ilv);
    return (code[2] == 1'b0) || (code == 3'b111 && !ilv);
  endfunction

  function automatic logic [COL_W-1:0] low_mask(input logic [LG_W-1:0] lg);
    return COL_W'((32'd1 << lg) - 32'd1);
  endfunction

  function automatic logic [COL_W-1:0] beat_col(input logic [COL_W-1:0] base,
                                                input logic [COL_W-1:0] beat,
                                                input burst_cfg_t cfg);
    logic [COL_W-1:0] m;
    m = low_mask(cfg.lg);
    if (cfg.full)     return base + beat;
    else if (cfg.ilv) return (base & ~m) | ((base ^ beat) & m);
    else              return (base & ~m) | ((base + beat) & m);
  endfunction

  function automatic logic is_last(input logic [COL_W-1:0] beat, input burst_cfg_t cfg);
    return !cfg.full && (beat == low_mask(cfg.lg));
  endfunction
endpackage

// File: rtl/sdram_col_decode.sv
module sdram_col_decode
  import sdram_col_pkg::*;
(
  input  logic       cmd_rd,
  input  logic       cmd_wr,
  input  logic [2:0] bl_code,
  input  logic       bt_ilv,
  input  logic       wr_single,
  output logic       load,
  output burst_cfg_t cfg
);
  logic single;

  always_comb begin
    single   = cmd_wr && !cmd_rd && wr_single;
    load     = (cmd_rd || cmd_wr) && (single || cfg_ok(bl_code, bt_ilv));
    cfg.full = !single && (bl_code == 3'b111);
    cfg.ilv  = !single && bt_ilv;
    cfg.lg   = single ? '0 : bl_code[LG_W-1:0];
  end
endmodule

// File: rtl/sdram_col_ctrl.sv
module sdram_col_ctrl
  import sdram_col_pkg::*;
#(
  parameter int CW = COL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          end_req,
  input  logic [CW-1:0] start_col,
  input  burst_cfg_t    cfg_in,
  output logic          busy,
  output logic [CW-1:0] base,
  output logic [CW-1:0] beat,
  output burst_cfg_t    cfg_q,
  output logic          last
);
  assign last = busy && is_last(beat, cfg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      base  <= '0;
      beat  <= '0;
      cfg_q <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      base  <= start_col;
      beat  <= '0;
      cfg_q <= cfg_in;
    end else if (end_req) begin
      busy <= 1'b0;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      beat <= beat + 1'b1;
    end
  end
endmodule

// File: rtl/sdram_col_map.sv
module sdram_col_map
  import sdram_col_pkg::*;
#(
  parameter int CW = COL_W
) (
  input  logic          busy,
  input  logic [CW-1:0] base,
  input  logic [CW-1:0] beat,
  input  burst_cfg_t    cfg,
  output logic [CW-1:0] col
);
  assign col = busy ? beat_col(base, beat, cfg) : '0;
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import sdram_col_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_stop,
  input  logic             cmd_pre,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             bt_ilv,
  input  logic             wr_single,
  output logic [COL_W-1:0] col_out,
  output logic             busy
);
  // Named internal events for the checker
  logic             load_w;
  logic             end_req_w;
  logic             last_w;
  logic             full_q;
  burst_cfg_t       cfg_new;
  burst_cfg_t       cfg_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;

  assign end_req_w = cmd_stop || cmd_pre;
  assign full_q    = cfg_q.full;

  sdram_col_decode u_dec (
    .cmd_rd    (cmd_rd),
    .cmd_wr    (cmd_wr),
    .bl_code   (bl_code),
    .bt_ilv    (bt_ilv),
    .wr_single (wr_single),
    .load      (load_w),
    .cfg       (cfg_new)
  );

  sdram_col_ctrl #(.CW(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_w),
    .end_req   (end_req_w),
    .start_col (start_col),
    .cfg_in    (cfg_new),
    .busy      (busy),
    .base      (base_q),
    .beat      (beat_q),
    .cfg_q     (cfg_q),
    .last      (last_w)
  );

  sdram_col_map #(.CW(COL_W)) u_map (
    .busy (busy),
    .base (base_q),
    .beat (beat_q),
    .cfg  (cfg_q),
    .col  (col_out)
  );
endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_rd,
  input logic          cmd_stop,
  input logic          cmd_pre,
  input logic [CW-1:0] start_col,
  input logic [2:0]    bl_code,
  input logic          bt_ilv,
  input logic [CW-1:0] col_out,
  input logic          busy,
  input logic          load_w,
  input logic          last_w,
  input logic          full_q
);
  always_comb begin
    if (rst_n && !busy) AST_IDLE_ZERO: assert (col_out == '0); // R1
  end

  AST_START_COL: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> (busy && col_out == $past(start_col))); // R2

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_w && !load_w) |=> !busy); // R2

  AST_BLOCK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !full_q && !last_w && !load_w && !cmd_stop && !cmd_pre)
    |=> (col_out[CW-1:3] == $past(col_out[CW-1:3]))); // R3

  AST_PAGE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && full_q && !load_w && !cmd_stop && !cmd_pre)
    |=> (busy && col_out == CW'($past(col_out) + 1'b1))); // R5

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_stop || cmd_pre) && !load_w) |=> (!busy && col_out == '0)); // R6

  AST_REJECT_PAGE_ILV: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd && bt_ilv && bl_code == 3'b111 && !busy) |=> !busy); // R8
endmodule

bind sdram_col_seq sdram_col_seq_chk #(.CW(sdram_col_pkg::COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_rd    (cmd_rd),
  .cmd_stop  (cmd_stop),
  .cmd_pre   (cmd_pre),
  .start_col (start_col),
  .bl_code   (bl_code),
  .bt_ilv    (bt_ilv),
  .col_out   (col_out),
  .busy      (busy),
  .load_w    (load_w),
  .last_w    (last_w),
  .full_q    (full_q)
);

// File: tb/sdram_col_seq_tb.sv
`timescale 1ns/1ps
module sdram_col_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_rd, cmd_wr, cmd_stop, cmd_pre, bt_ilv, wr_single;
  logic [7:0] start_col;
  logic [2:0] bl_code;
  logic [7:0] col_out;
  logic       busy;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sdram_col_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .cmd_stop(cmd_stop), .cmd_pre(cmd_pre), .start_col(start_col),
    .bl_code(bl_code), .bt_ilv(bt_ilv), .wr_single(wr_single),
    .col_out(col_out), .busy(busy)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected column from the start offset inside its block
  function automatic logic [7:0] exp_col(input int st, input int n, input int len,
                                         input bit ilv, input bit full);
    int off, blk;
    if (full) return 8'((st + n) % 256);
    off = st % len;
    blk = st - off;
    if (ilv) return 8'(blk + (off ^ n));
    return 8'(blk + ((off + n) % len));
  endfunction

  task automatic clear_in();
    cmd_rd = 0; cmd_wr = 0; cmd_stop = 0; cmd_pre = 0;
  endtask

  // Called at a falling edge; returns one cycle later, at the falling edge after the command edge
  task automatic issue(input bit rd, input bit wr, input int st, input logic [2:0] code,
                       input bit ilv, input bit ws, input bit stp, input bit pre);
    cmd_rd = rd; cmd_wr = wr; cmd_stop = stp; cmd_pre = pre;
    start_col = 8'(st); bl_code = code; bt_ilv = ilv; wr_single = ws;
    @(negedge clk);
    clear_in();
  endtask

  task automatic beat(input string tag, input logic [7:0] exp);
    chk(tag, {7'd0, busy}, 8'd1);
    chk(tag, col_out, exp);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    chk(tag, {7'd0, busy}, 8'd0);
    chk(tag, col_out, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements) actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; clear_in(); start_col = 0; bl_code = 0; bt_ilv = 0; wr_single = 0;
    repeat (3) @(negedge clk);
    idle("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    idle("R1 after reset");

    // Exhaustive sweep: fixed lengths, both orders, all start columns (R2 R3 R4)
    for (int code = 0; code < 4; code++)
      for (int il = 0; il < 2; il++)
        for (int st = 0; st < 256; st++) begin
          issue(1, 0, st, 3'(code), il[0], 0, 0, 0);
          for (int n = 0; n < (1 << code); n++)
            beat(il ? "R4 interleaved beat" : "R3 sequential beat",
                 exp_col(st, n, 1 << code, il[0], 0));
          idle("R2 burst length end");
        end

    // Full page wraps and runs until stopped (R5, R6)
    issue(1, 0, 8'hF0, 3'b111, 0, 0, 0, 0);
    for (int n = 0; n < 300; n++) beat("R5 full page", exp_col(8'hF0, n, 256, 0, 1));
    issue(0, 0, 0, 3'b000, 0, 0, 1, 0);
    idle("R6 stop ends full page");

    // Precharge mid-burst (R6)
    issue(1, 0, 8'h40, 3'b011, 0, 0, 0, 0);
    beat("R6 pre-run", 8'h40);
    chk("R6 before precharge", col_out, 8'h41);
    issue(0, 0, 0, 3'b000, 0, 0, 0, 1);
    idle("R6 precharge ends burst");

    // Restart mid-burst with stop in the same cycle (R7)
    issue(1, 0, 8'h1C, 3'b011, 0, 0, 0, 0);
    beat("R7 first burst", 8'h1C);
    beat("R7 first burst", 8'h1D);
    chk("R7 first burst", col_out, 8'h1E);
    issue(1, 0, 8'h25, 3'b010, 1, 0, 1, 0);
    for (int n = 0; n < 4; n++) beat("R7 restart interleaved", exp_col(8'h25, n, 4, 1, 0));
    idle("R7 restart end");

    // Read wins over write with write-single set (R7)
    issue(1, 1, 8'h6B, 3'b011, 0, 1, 0, 0);
    for (int n = 0; n < 8; n++) beat("R7 read priority", exp_col(8'h6B, n, 8, 0, 0));
    idle("R7 read priority end");

    // Invalid settings ignored mid-burst and when idle (R8)
    issue(1, 0, 8'h0A, 3'b010, 0, 0, 0, 0);
    chk("R8 pre-run", col_out, 8'h0A);
    issue(1, 0, 8'h99, 3'b111, 1, 0, 0, 0);
    beat("R8 burst continues", 8'h0B);
    beat("R8 burst continues", 8'h08);
    beat("R8 burst continues", 8'h09);
    idle("R8 burst end");
    issue(1, 0, 8'h77, 3'b101, 0, 0, 0, 0);
    idle("R8 reserved code idle");
    issue(0, 1, 8'h77, 3'b111, 1, 0, 0, 0);
    idle("R8 page interleave write idle");

    // Write-single option (R9)
    issue(0, 1, 8'h33, 3'b011, 1, 1, 0, 0);
    beat("R9 single write", 8'h33);
    idle("R9 single write end");
    issue(0, 1, 8'h33, 3'b111, 1, 1, 0, 0);
    beat("R9 single write invalid code", 8'h33);
    idle("R9 single write invalid code end");
    issue(1, 0, 8'h35, 3'b011, 0, 1, 0, 0);
    for (int n = 0; n < 8; n++) beat("R9 read keeps length", exp_col(8'h35, n, 8, 0, 0));
    idle("R9 read end");
    issue(0, 1, 8'h52, 3'b010, 0, 0, 0, 0);
    for (int n = 0; n < 4; n++) beat("R9 normal write", exp_col(8'h52, n, 4, 0, 0));
    idle("R9 normal write end");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule